// File: doc/BRIEF.md
# Sixteen-Point Twiddle Rotator Without Multipliers

This block turns one complex sample (real part `x`, imaginary part `y`) through the twiddle angle −phi·π/8, where phi is a 4-bit index from 0 to 15. It is meant to sit between two butterfly stages of a pipelined FFT, where each sample in a stream needs its own twiddle factor taken from the sixteenth roots of unity. The block has no general multiplier and no coefficient table.

The two low bits of phi select one of four base rotations. Each base rotation is built from three constants: cos π/8, sin π/8 and cos π/4. These are written as fixed shift-and-add sums. The terms of each sum are chosen by multiplexers placed in front of one shared adder chain per product. The angle 3π/8 reuses the π/8 constants with the cosine and sine roles exchanged. The two high bits of phi select a quarter turn. That quarter turn is applied after rounding, by swapping the real and imaginary parts and negating them.

The block is a two-stage pipeline with a valid bit travelling alongside the data. The output is one bit wider than the input, so no result can overflow.

Top module: `w16_rotator`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_re` and `out_im` are all 0 after that edge.
- R2: A sample accepted with `in_valid` high at edge k appears with `out_valid` high after edge k+1. A cycle without `in_valid` gives a cycle without `out_valid` at the same distance, so gaps are preserved.
- R3: For the base index r = `in_phi[1:0]`, with coefficients C and S, the block computes the unrounded sums `Ax = x·C + y·S` and `Ay = y·C − x·S`. The field `in_phi` is unsigned.
- R4: The coefficient pairs (C, S), scaled by 4096, are: r=0 gives (4096, 0); r=1 gives (3784, 1567); r=2 gives (2896, 2896); r=3 gives (1567, 3784). The pair for r=3 is the pair for r=1 with its two values exchanged.
- R5: Each base result is floor((A + 2048) / 4096). The result is a signed value DATA_W+1 bits wide and never wraps.
- R6: When phi is a multiple of 4, the result is exact. phi=0 gives (x, y); phi=4 gives (y, −x); phi=8 gives (−x, −y); phi=12 gives (−y, x).
- R7: Let q = `in_phi[3:2]` and let (bx, by) be the rounded base result. The output is (bx, by) when q=0, (by, −bx) when q=1, (−bx, −by) when q=2, and (−by, bx) when q=3.
- R8: `out_re` and `out_im` hold their last values in every cycle where `out_valid` is low.
- R9: Full-scale inputs, including −2^(DATA_W−1) on either part, give correct results for every phi. For example, phi=8 with x = −32768 gives +32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample is valid this cycle |
| in_re | input | DATA_W | Real part x, two's complement |
| in_im | input | DATA_W | Imaginary part y, two's complement |
| in_phi | input | 4 | Twiddle index; angle −phi·π/8 |
| out_valid | output | 1 | Output sample is valid |
| out_re | output | DATA_W+1 | Rotated real part |
| out_im | output | DATA_W+1 | Rotated imaginary part |

## Verification
Several internal faults show up at the ports two cycles after the affected input:

- A wrong shift or sign in one multiplexed term appears as an error scaled by a power of two. It shows only for the base indices that use that term, so all sixteen phi values are driven with both large and small operands.
- A fault in the quarter-turn mapping swaps or negates whole components for one value of q.
- A broken rounding offset leaves the exact multiples of four untouched but moves odd-index results by one.
- A stuck or misaligned valid stage desynchronises the bench queue from the first sample on. It also appears as a changed output in a cycle where `out_valid` is low.

// File: rtl/w16rot_pkg.sv
// Shared constants, types and coefficient decomposition for the W16 rotator.
// Assumes 12 fractional bits for all rotation constants.
package w16rot_pkg;

    localparam int FRAC_W  = 12;
    localparam int N_TERMS = 5;

    // Constant selector for one product network.
    typedef enum logic [2:0] {
        K_ZERO = 3'd0,
        K_ONE  = 3'd1,
        K_C8   = 3'd2,
        K_S8   = 3'd3,
        K_C4   = 3'd4
    } coef_e;

    // One signed power-of-two term of a constant.
    typedef struct packed {
        logic       en;
        logic       neg;
        logic [3:0] sh;
    } term_t;

    typedef struct packed {
        coef_e c;
        coef_e s;
    } pair_t;

    // Signed-digit decompositions (scaled by 4096):
    // 4096 = 2^12; 3784 = 2^12-2^8-2^6+2^3; 1567 = 2^10+2^9+2^5-2^0;
    // 2896 = 2^11+2^10-2^7-2^6+2^4.
    function automatic term_t coef_term(coef_e k, int unsigned slot);
        term_t t;
        t = '0;
        case (k)
            K_ONE: if (slot == 0) t = '{1'b1, 1'b0, 4'd12};
            K_C8: case (slot)
                0: t = '{1'b1, 1'b0, 4'd12};
                1: t = '{1'b1, 1'b1, 4'd8};
                2: t = '{1'b1, 1'b1, 4'd6};
                3: t = '{1'b1, 1'b0, 4'd3};
                default: t = '0;
            endcase
            K_S8: case (slot)
                0: t = '{1'b1, 1'b0, 4'd10};
                1: t = '{1'b1, 1'b0, 4'd9};
                2: t = '{1'b1, 1'b0, 4'd5};
                3: t = '{1'b1, 1'b1, 4'd0};
                default: t = '0;
            endcase
            K_C4: case (slot)
                0: t = '{1'b1, 1'b0, 4'd11};
                1: t = '{1'b1, 1'b0, 4'd10};
                2: t = '{1'b1, 1'b1, 4'd7};
                3: t = '{1'b1, 1'b1, 4'd6};
                4: t = '{1'b1, 1'b0, 4'd4};
                default: t = '0;
            endcase
            default: t = '0;
        endcase
        return t;
    endfunction

    // Base pair per low index; index 3 reuses the pi/8 constants swapped.
    function automatic pair_t base_pair(logic [1:0] r);
        pair_t p;
        case (r)
            2'd0:    p = '{K_ONE, K_ZERO};
            2'd1:    p = '{K_C8,  K_S8};
            2'd2:    p = '{K_C4,  K_C4};
            default: p = '{K_S8,  K_C8};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/w16rot_cmul.sv
// Multiplexed shift-and-add constant multiplier.
// Each term slot picks a shift and sign from the selected constant; all
// constants share the same adder chain. Assumes ACC_W covers 2^13 * input.
module w16rot_cmul
    import w16rot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = DATA_W + 1 + FRAC_W
) (
    input  coef_e                     sel,
    input  logic signed [DATA_W-1:0]  val,
    output logic signed [ACC_W-1:0]   prod
);

    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] term [N_TERMS];

    assign ext = ACC_W'(val);

    for (genvar g = 0; g < N_TERMS; g++) begin : g_slot
        term_t                   tsel;
        logic signed [ACC_W-1:0] shifted;

        // Term mux: shift and sign selected by the active constant.
        always_comb begin
            tsel    = coef_term(sel, g);
            shifted = ext <<< tsel.sh;
            if (!tsel.en)      term[g] = '0;
            else if (tsel.neg) term[g] = -shifted;
            else               term[g] = shifted;
        end
    end

    // Shared adder chain over all term slots.
    always_comb begin
        prod = '0;
        for (int i = 0; i < N_TERMS; i++) prod = prod + term[i];
    end

endmodule

// File: rtl/w16rot_stage1.sv
// Pipeline stage 1: selects the base coefficient pair from phi[1:0] and
// forms the four partial products x*C, y*S, y*C, x*S. Registers them with
// the quarter-turn index and the valid bit.
module w16rot_stage1
    import w16rot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = DATA_W + 1 + FRAC_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic signed [DATA_W-1:0]     in_re,
    input  logic signed [DATA_W-1:0]     in_im,
    input  logic [3:0]                   in_phi,
    output logic                         s1_valid,
    output logic [1:0]                   s1_quad,
    output logic [3:0][ACC_W-1:0]        s1_prod
);

    localparam int N_LANES = 4;

    pair_t                   pair;
    logic signed [ACC_W-1:0] prod_c [N_LANES];

    assign pair = base_pair(in_phi[1:0]);

    // Lanes: 0 = x*C, 1 = y*S, 2 = y*C, 3 = x*S.
    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        localparam bit USE_X = (l == 0) || (l == 3);
        localparam bit USE_C = (l == 0) || (l == 2);

        w16rot_cmul #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_cmul (
            .sel  (USE_C ? pair.c : pair.s),
            .val  (USE_X ? in_re : in_im),
            .prod (prod_c[l])
        );
    end

    // Stage register: products captured only for valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_quad  <= '0;
            s1_prod  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_quad <= in_phi[3:2];
                for (int i = 0; i < N_LANES; i++) s1_prod[i] <= prod_c[i];
            end
        end
    end

endmodule

// File: rtl/w16rot_stage2.sv
// Pipeline stage 2: sums products, rounds (add half, floor) to DATA_W+1
// bits, then applies the quarter turn by swap and negate.
// Assumes the product width equals FRAC_W + DATA_W + 1.
module w16rot_stage2
    import w16rot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = DATA_W + 1 + FRAC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       s1_valid,
    input  logic [1:0]                 s1_quad,
    input  logic [3:0][ACC_W-1:0]      s1_prod,
    output logic                       out_valid,
    output logic signed [DATA_W:0]     out_re,
    output logic signed [DATA_W:0]     out_im
);

    localparam int OUT_W = DATA_W + 1;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W - 1);

    logic signed [ACC_W-1:0]  sum_re, sum_im;
    logic signed [OUT_W-1:0]  bx, by, rot_re, rot_im;
    logic [FRAC_W-1:0]        frac_re_unused, frac_im_unused;

    // Base rotation sums with rounding offset.
    always_comb begin
        sum_re = $signed(s1_prod[0]) + $signed(s1_prod[1]) + HALF;
        sum_im = $signed(s1_prod[2]) - $signed(s1_prod[3]) + HALF;
    end

    assign {bx, frac_re_unused} = sum_re;
    assign {by, frac_im_unused} = sum_im;

    // Quarter-turn mapping by swap and negation.
    always_comb begin
        case (s1_quad)
            2'd0:    begin rot_re = bx;  rot_im = by;  end
            2'd1:    begin rot_re = by;  rot_im = -bx; end
            2'd2:    begin rot_re = -bx; rot_im = -by; end
            default: begin rot_re = -by; rot_im = bx;  end
        endcase
    end

    // Output register: data updated only for valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_re <= rot_re;
                out_im <= rot_im;
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> ($stable(out_re) && $stable(out_im))); // R8

endmodule

// File: rtl/w16_rotator.sv
// Top: multiplier-less rotator by W16^phi, two-stage pipeline.
// Assumes phi is sampled together with the data under in_valid.
module w16_rotator
    import w16rot_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    input  logic [3:0]               in_phi,
    output logic                     out_valid,
    output logic signed [DATA_W:0]   out_re,
    output logic signed [DATA_W:0]   out_im
);

    localparam int ACC_W = DATA_W + 1 + FRAC_W;

    logic                  s1_valid;
    logic [1:0]            s1_quad;
    logic [3:0][ACC_W-1:0] s1_prod;

    w16rot_stage1 #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_stage1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_re    (in_re),
        .in_im    (in_im),
        .in_phi   (in_phi),
        .s1_valid (s1_valid),
        .s1_quad  (s1_quad),
        .s1_prod  (s1_prod)
    );

    w16rot_stage2 #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_stage2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_quad   (s1_quad),
        .s1_prod   (s1_prod),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    AST_VALID_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid); // R2
    AST_VALID_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid); // R2
    AST_PHI0_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_phi == 4'd0) |=> ##1
        (out_valid && out_re == $past(in_re, 2) && out_im == $past(in_im, 2))); // R6
    AST_PHI8_NEGATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_phi == 4'd8) |=> ##1
        (out_valid && out_re == -$past(in_re, 2) && out_im == -$past(in_im, 2))); // R9

endmodule

// File: tb/w16_rotator_bench.sv
// Bench: directed corners plus seeded random stream, scoreboard queue.
module w16_rotator_bench;

    localparam int DATA_W = 16;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_re = '0;
    logic signed [DATA_W-1:0] in_im = '0;
    logic [3:0]               in_phi = '0;
    logic                     out_valid;
    logic signed [DATA_W:0]   out_re, out_im;

    int n_chk = 0;
    int n_err = 0;
    bit v_d1 = 0, v_d2 = 0;
    int last_re = 0, last_im = 0;
    int q_re[$], q_im[$];
    string q_tag[$];

    always #5 clk = ~clk;

    w16_rotator #(.DATA_W(DATA_W)) u_w16_rotator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re),
        .in_im(in_im), .in_phi(in_phi), .out_valid(out_valid),
        .out_re(out_re), .out_im(out_im)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference from the requirements: R3/R4 sums, R5 rounding, R7 quarter turn.
    function automatic void model(input int x, input int y, input int phi,
                                  output int ex, output int ey);
        longint c, s, ax, ay, bx, by;
        case (phi % 4)
            0: begin c = 4096; s = 0;    end
            1: begin c = 3784; s = 1567; end
            2: begin c = 2896; s = 2896; end
            default: begin c = 1567; s = 3784; end
        endcase
        ax = longint'(x) * c + longint'(y) * s;
        ay = longint'(y) * c - longint'(x) * s;
        bx = (ax + 2048) >>> 12;
        by = (ay + 2048) >>> 12;
        case (phi / 4)
            0: begin ex = int'(bx);  ey = int'(by);  end
            1: begin ex = int'(by);  ey = -int'(bx); end
            2: begin ex = -int'(bx); ey = -int'(by); end
            default: begin ex = -int'(by); ey = int'(bx); end
        endcase
    endfunction

    // Per-cycle: check outputs at negedge, then drive next input.
    task automatic step(input bit v, input int x, input int y, input int phi,
                        input string tag);
        int ex, ey;
        @(negedge clk);
        chk(int'(out_valid), int'(v_d2), "R2 valid latency");
        if (out_valid) begin
            if (q_re.size() > 0) begin
                chk(int'(out_re), q_re.pop_front(), {q_tag[0], " re"});
                chk(int'(out_im), q_im.pop_front(), {q_tag[0], " im"});
                void'(q_tag.pop_front());
            end
            last_re = int'(out_re);
            last_im = int'(out_im);
        end else begin
            chk(int'(out_re), last_re, "R8 hold re");
            chk(int'(out_im), last_im, "R8 hold im");
        end
        v_d2 = v_d1;
        v_d1 = v;
        in_valid = v;
        in_re = DATA_W'(x);
        in_im = DATA_W'(y);
        in_phi = 4'(phi);
        if (v) begin
            model(x, y, phi, ex, ey);
            q_re.push_back(ex);
            q_im.push_back(ey);
            q_tag.push_back(tag);
        end
    endtask

    function automatic string tag_for(input int x, input int y, input int phi);
        if (x == -32768 || y == -32768 || x == 32767 || y == 32767) return "R9";
        if (phi % 4 == 0) return "R6";
        if (phi >= 4) return "R7";
        return "R3 R4 R5";
    endfunction

    initial begin : watchdog
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int sd;
        sd = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(int'(out_valid), 0, "R1 reset valid");
        chk(int'(out_re), 0, "R1 reset re");
        chk(int'(out_im), 0, "R1 reset im");
        rst_n = 1'b1;
        // All sixteen angles on a mid-size operand.
        for (int p = 0; p < 16; p++) step(1, 1000, -300, p, tag_for(1000, -300, p));
        // Rounding near half: small odd operands.
        for (int p = 0; p < 16; p++) step(1, 3, 1, p, tag_for(3, 1, p));
        // Full-scale corners on every angle.
        for (int p = 0; p < 16; p++) step(1, -32768, -32768, p, "R9");
        for (int p = 0; p < 16; p++) step(1, 32767, -32768, p, "R9");
        for (int p = 0; p < 16; p++) step(1, -32768, 32767, p, "R9");
        // Gap pattern for latency and hold.
        step(1, 1234, 567, 5, "R7");
        step(0, 999, 999, 3, "none");
        step(0, -5, 7, 1, "none");
        step(1, 77, -88, 2, "R3 R4 R5");
        step(0, 11, 22, 9, "none");
        step(1, 32767, 32767, 8, "R9");
        // Seeded random stream.
        for (int i = 0; i < 4000; i++) begin
            bit v;
            int x, y, p;
            v = ($urandom_range(9) < 7);
            x = int'($urandom_range(65535)) - 32768;
            y = int'($urandom_range(65535)) - 32768;
            p = int'($urandom_range(15));
            step(v, x, y, p, tag_for(x, y, p));
        end
        // Drain.
        repeat (4) step(0, 0, 0, 0, "none");
        chk(q_re.size(), 0, "R2 all samples delivered");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule